// File: doc/BRIEF.md
# Switching Regulator Output Sequencer

This block is the digital sequencer for the outputs of a multi-output step-down regulator. One channel per output turns a raw enable pin, supply-status flags and protection-comparator flags into a switching-enable, soft-start status and an open-drain power-good drive. All channels share one power-on stage. When the bias rail is reported good, that stage holds a fixed initialization window. It pulses a configuration-capture strobe once at the start of the window, and only after the window ends do the channels act on enable or input-supply status.

Each channel filters its enable asymmetrically. A long stable-high period is needed before the enable is accepted, and a short stable-low period before it is dropped. A channel then runs a timed soft-start. It releases power-good only after the ramp finishes with no fault present.

The faults act in different ways:
- Input undervoltage, overcurrent and deglitched overvoltage send the channel into a hiccup wait. The wait is re-armed for as long as the fault is still present when it expires.
- Overtemperature has no timer. The channel restarts as soon as the flag clears.
- Overvoltage is watched only once soft-start is complete.

Every duration is counted in ticks of a single-cycle microsecond timebase and set by a parameter.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is held, every channel has switching off, soft-start active low, ramp-done low and power-good pulled low (pg_low = 1), and cfg_load is low.
- R2: A rise of bias_ok gives exactly one single-cycle cfg_load pulse. No channel switches until INIT_US ticks have passed in the initialization window starting with that pulse. After the window, a channel whose input undervoltage flag is set does not start, and it starts on the cycle after the flag clears.
- R3: A raw enable rise is accepted only after it has stayed high for EN_RISE_US ticks as seen through a two-flop synchronizer. A shorter high pulse is ignored.
- R4: A raw enable fall is accepted after EN_FALL_US ticks, and switching stops on the next cycle with power-good pulled low. A low pulse shorter than that is ignored.
- R5: Soft-start begins when the filtered enable is high, the input is not under voltage and there is no overtemperature. ss_active stays high for exactly SS_US ticks. Then ss_done rises and power-good is released (pg_low = 0). All qualifying channels start in the same cycle.
- R6: Input undervoltage on a switching channel turns switching off on the next cycle and pulls power-good low.
- R7: After an undervoltage, overcurrent or overvoltage shutdown, switching stays off for exactly HICCUP_US ticks. If the fault has cleared, the channel then restarts soft-start.
- R8: If the fault is still present when the hiccup wait ends, a new full wait begins without switching, so the off time is a whole multiple of HICCUP_US ticks.
- R9: Overtemperature stops switching on every channel on the next cycle. Once it clears, enabled channels restart soft-start on the very next cycle with no hiccup wait.
- R10: The overvoltage flag has no effect during soft-start. After soft-start it must be present on OVDG_US consecutive ticks before the channel shuts down; a shorter pulse is ignored.
- R11: Overcurrent on a switching channel turns switching off on the next cycle.
- R12: A fault, enable change or hiccup on one channel leaves the outputs of every other channel unchanged.
- R13: Loss of bias_ok turns all switching off within two cycles and restarts the initialization window on its return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous-assert reset, sampled synchronously |
| us_tick | input | 1 | Single-cycle pulse once per microsecond |
| bias_ok | input | 1 | Internal bias rail above its good threshold |
| ot_flt | input | 1 | Die overtemperature flag, shared by all channels |
| vin_uv | input | NCH | Per-channel input supply under voltage |
| en_raw | input | NCH | Raw, asynchronous per-channel enable pins |
| ov_flt | input | NCH | Per-channel output overvoltage comparator |
| oc_flt | input | NCH | Per-channel overcurrent event (positive or negative) |
| cfg_load | output | 1 | One-cycle strobe to capture configuration straps |
| sw_en | output | NCH | Switching enable per channel |
| ss_active | output | NCH | Soft-start ramp running |
| ss_done | output | NCH | Ramp complete, channel in regulation |
| pg_low | output | NCH | Power-good pull-down drive (1 = pull low) |

## Verification
The interesting collision is a hiccup wait expiring in the same cycle in which its fault is still asserted. The channel must choose a re-arm over a restart. The bench provokes this by holding overcurrent past the first expiry and releasing it partway through the second. It then requires the count of off-state ticks to be exactly twice the hiccup length. A second overlap is an overvoltage pulse during soft-start, where the ramp timer and the overvoltage input are both active. The bench judges that case by requiring the soft-start tick count to stay exact and no shutdown to occur.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

  typedef enum logic [2:0] {
    CH_IDLE   = 3'd0,
    CH_SOFT   = 3'd1,
    CH_RUN    = 3'd2,
    CH_HICCUP = 3'd3,
    CH_OTWAIT = 3'd4
  } ch_state_e;

  typedef enum logic [1:0] {
    BOOT_OFF   = 2'd0,
    BOOT_LOAD  = 2'd1,
    BOOT_READY = 2'd2
  } boot_state_e;

  // bits for a counter that holds 0 .. span-1
  function automatic int span_bits(input int span);
    return (span < 2) ? 1 : $clog2(span);
  endfunction

  function automatic int larger(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic drives_switch(input ch_state_e s);
    return (s == CH_SOFT) || (s == CH_RUN);
  endfunction

  function automatic logic releases_pg(input ch_state_e s);
    return s == CH_RUN;
  endfunction

endpackage

// File: rtl/rail_seq_boot.sv
module rail_seq_boot #(
  parameter int INIT_US = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic bias_ok,
  output logic cfg_load,
  output logic init_done
);
  import rail_seq_pkg::*;

  localparam int CW = span_bits(INIT_US);
  localparam logic [CW-1:0] LAST = CW'(INIT_US - 1);

  boot_state_e st;
  logic [CW-1:0] cnt;
  logic          win_end;

  assign win_end = us_tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= BOOT_OFF;
      cnt      <= '0;
      cfg_load <= 1'b0;
    end else begin
      cfg_load <= 1'b0;
      if (!bias_ok) begin
        st  <= BOOT_OFF;
        cnt <= '0;
      end else begin
        case (st)
          BOOT_OFF: begin
            st       <= BOOT_LOAD;
            cnt      <= '0;
            cfg_load <= 1'b1;
          end
          BOOT_LOAD: begin
            if (win_end) begin
              st  <= BOOT_READY;
              cnt <= '0;
            end else if (us_tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= BOOT_READY;
        endcase
      end
    end
  end

  assign init_done = (st == BOOT_READY);

endmodule

// File: rtl/rail_seq_enflt.sv
module rail_seq_enflt #(
  parameter int RISE_US = 200,
  parameter int FALL_US = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic en_raw,
  output logic en_filt
);
  import rail_seq_pkg::*;

  localparam int CW = span_bits(larger(RISE_US, FALL_US));
  localparam logic [CW-1:0] RLAST = CW'(RISE_US - 1);
  localparam logic [CW-1:0] FLAST = CW'(FALL_US - 1);

  logic [1:0]    sync_q;
  logic          en_s;
  logic          filt_q;
  logic [CW-1:0] cnt;
  logic          hold_hit;

  assign en_s     = sync_q[1];
  assign hold_hit = us_tick && (en_s ? (cnt == RLAST) : (cnt == FLAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
      filt_q <= 1'b0;
      cnt    <= '0;
    end else begin
      sync_q <= {sync_q[0], en_raw};
      if (en_s == filt_q) begin
        cnt <= '0;
      end else if (us_tick) begin
        if (hold_hit) begin
          filt_q <= en_s;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign en_filt = filt_q;

endmodule

// File: rtl/rail_seq_chan.sv
module rail_seq_chan #(
  parameter int SS_US     = 3000,
  parameter int HICCUP_US = 20000,
  parameter int OVDG_US   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic init_done,
  input  logic en_filt,
  input  logic vin_uv,
  input  logic ov_flt,
  input  logic oc_flt,
  input  logic ot_flt,
  output logic sw_en,
  output logic ss_active,
  output logic ss_done,
  output logic pg_low,
  output logic ov_trip,
  output logic hic_end
);
  import rail_seq_pkg::*;

  localparam int CW = span_bits(larger(SS_US, HICCUP_US));
  localparam int OW = span_bits(OVDG_US);
  localparam logic [CW-1:0] SLAST = CW'(SS_US - 1);
  localparam logic [CW-1:0] HLAST = CW'(HICCUP_US - 1);
  localparam logic [OW-1:0] OLAST = OW'(OVDG_US - 1);

  ch_state_e     st, st_n;
  logic [CW-1:0] cnt;
  logic [OW-1:0] ovc;
  logic          ss_end, may_start, hic_clear, stop_hic;

  assign ss_end    = us_tick && (st == CH_SOFT) && (cnt == SLAST);
  assign hic_end   = us_tick && (st == CH_HICCUP) && (cnt == HLAST);
  assign ov_trip   = (st == CH_RUN) && ov_flt && us_tick && (ovc == OLAST);
  assign may_start = en_filt && !vin_uv && !ot_flt;
  assign hic_clear = !vin_uv && !oc_flt && !ov_flt;
  assign stop_hic  = vin_uv || oc_flt;

  always_comb begin
    st_n = st;
    if (!init_done) begin
      st_n = CH_IDLE;
    end else begin
      case (st)
        CH_IDLE:   if (may_start) st_n = CH_SOFT;
        CH_SOFT: begin
          if (ot_flt)        st_n = CH_OTWAIT;
          else if (stop_hic) st_n = CH_HICCUP;
          else if (!en_filt) st_n = CH_IDLE;
          else if (ss_end)   st_n = CH_RUN;
        end
        CH_RUN: begin
          if (ot_flt)                   st_n = CH_OTWAIT;
          else if (stop_hic || ov_trip) st_n = CH_HICCUP;
          else if (!en_filt)            st_n = CH_IDLE;
        end
        CH_HICCUP: begin
          if (hic_end) begin
            if (ot_flt)          st_n = CH_OTWAIT;
            else if (!hic_clear) st_n = CH_HICCUP;
            else if (may_start)  st_n = CH_SOFT;
            else                 st_n = CH_IDLE;
          end
        end
        CH_OTWAIT: if (!ot_flt) st_n = may_start ? CH_SOFT : CH_IDLE;
        default:   st_n = CH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= CH_IDLE;
      cnt <= '0;
      ovc <= '0;
    end else begin
      st <= st_n;
      if ((st_n != st) || hic_end)
        cnt <= '0;
      else if (us_tick && ((st == CH_SOFT) || (st == CH_HICCUP)))
        cnt <= cnt + 1'b1;
      if ((st != CH_RUN) || !ov_flt || ov_trip)
        ovc <= '0;
      else if (us_tick)
        ovc <= ovc + 1'b1;
    end
  end

  assign sw_en     = drives_switch(st);
  assign ss_active = (st == CH_SOFT);
  assign ss_done   = releases_pg(st);
  assign pg_low    = !releases_pg(st);

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
  parameter int NCH        = 2,
  parameter int INIT_US    = 800,
  parameter int EN_RISE_US = 200,
  parameter int EN_FALL_US = 2,
  parameter int SS_US      = 3000,
  parameter int HICCUP_US  = 20000,
  parameter int OVDG_US    = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           us_tick,
  input  logic           bias_ok,
  input  logic           ot_flt,
  input  logic [NCH-1:0] vin_uv,
  input  logic [NCH-1:0] en_raw,
  input  logic [NCH-1:0] ov_flt,
  input  logic [NCH-1:0] oc_flt,
  output logic           cfg_load,
  output logic [NCH-1:0] sw_en,
  output logic [NCH-1:0] ss_active,
  output logic [NCH-1:0] ss_done,
  output logic [NCH-1:0] pg_low
);

  logic           init_done_w;
  logic [NCH-1:0] en_filt_w;
  logic [NCH-1:0] ov_trip_w;
  logic [NCH-1:0] hic_end_w;

  rail_seq_boot #(.INIT_US(INIT_US)) boot_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .us_tick   (us_tick),
    .bias_ok   (bias_ok),
    .cfg_load  (cfg_load),
    .init_done (init_done_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    rail_seq_enflt #(.RISE_US(EN_RISE_US), .FALL_US(EN_FALL_US)) flt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .us_tick (us_tick),
      .en_raw  (en_raw[g]),
      .en_filt (en_filt_w[g])
    );

    rail_seq_chan #(.SS_US(SS_US), .HICCUP_US(HICCUP_US), .OVDG_US(OVDG_US)) chan_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .us_tick   (us_tick),
      .init_done (init_done_w),
      .en_filt   (en_filt_w[g]),
      .vin_uv    (vin_uv[g]),
      .ov_flt    (ov_flt[g]),
      .oc_flt    (oc_flt[g]),
      .ot_flt    (ot_flt),
      .sw_en     (sw_en[g]),
      .ss_active (ss_active[g]),
      .ss_done   (ss_done[g]),
      .pg_low    (pg_low[g]),
      .ov_trip   (ov_trip_w[g]),
      .hic_end   (hic_end_w[g])
    );
  end

endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bias_ok,
  input logic           ot_flt,
  input logic [NCH-1:0] vin_uv,
  input logic [NCH-1:0] ov_flt,
  input logic [NCH-1:0] oc_flt,
  input logic           cfg_load,
  input logic           init_done,
  input logic [NCH-1:0] en_filt,
  input logic [NCH-1:0] ov_trip,
  input logic [NCH-1:0] hic_end,
  input logic [NCH-1:0] sw_en,
  input logic [NCH-1:0] ss_active,
  input logic [NCH-1:0] ss_done,
  input logic [NCH-1:0] pg_low
);

  // R2
  cfg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !cfg_load);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R2
    start_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_en[i]) |-> $past(init_done));
    // R4
    en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_filt[i]) |=> !sw_en[i]);
    // R5
    pg_after_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pg_low[i]) |-> $past(ss_active[i]));
    // R5
    done_after_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ss_done[i]) |-> $past(ss_active[i]));
    // R6
    uv_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en[i] && vin_uv[i]) |=> !sw_en[i]);
    // R8
    hic_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hic_end[i] && (oc_flt[i] || vin_uv[i] || ov_flt[i])) |=> !sw_en[i]);
    // R9
    ot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ot_flt |=> !sw_en[i]);
    // R10
    ov_soft_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_active[i] && ov_flt[i] && en_filt[i] && !vin_uv[i] && !oc_flt[i] &&
       !ot_flt && init_done) |=> sw_en[i]);
    // R10
    ov_trip_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ov_trip[i] |=> !sw_en[i]);
    // R11
    oc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en[i] && oc_flt[i]) |=> !sw_en[i]);
    // R13
    bias_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bias_ok && $past(!bias_ok)) |=> !sw_en[i]);
  end

endmodule

bind rail_sequencer rail_seq_chk #(.NCH(NCH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bias_ok   (bias_ok),
  .ot_flt    (ot_flt),
  .vin_uv    (vin_uv),
  .ov_flt    (ov_flt),
  .oc_flt    (oc_flt),
  .cfg_load  (cfg_load),
  .init_done (init_done_w),
  .en_filt   (en_filt_w),
  .ov_trip   (ov_trip_w),
  .hic_end   (hic_end_w),
  .sw_en     (sw_en),
  .ss_active (ss_active),
  .ss_done   (ss_done),
  .pg_low    (pg_low)
);

// File: tb/rail_sequencer_tb_top.sv
module rail_sequencer_tb_top;
  localparam int NCH  = 2;
  localparam int INIT = 8;
  localparam int RISE = 5;
  localparam int FALL = 2;
  localparam int SS   = 10;
  localparam int HIC  = 12;
  localparam int OVDG = 3;
  localparam int TP   = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n = 1'b0, us_tick = 1'b0, bias_ok = 1'b0, ot_flt = 1'b0;
  logic [NCH-1:0] vin_uv = '0, en_raw = '0, ov_flt = '0, oc_flt = '0;
  logic           cfg_load;
  logic [NCH-1:0] sw_en, ss_active, ss_done, pg_low;

  rail_sequencer #(
    .NCH(NCH), .INIT_US(INIT), .EN_RISE_US(RISE), .EN_FALL_US(FALL),
    .SS_US(SS), .HICCUP_US(HIC), .OVDG_US(OVDG)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .bias_ok(bias_ok), .ot_flt(ot_flt),
    .vin_uv(vin_uv), .en_raw(en_raw), .ov_flt(ov_flt), .oc_flt(oc_flt),
    .cfg_load(cfg_load), .sw_en(sw_en), .ss_active(ss_active), .ss_done(ss_done),
    .pg_low(pg_low)
  );

  int n_chk = 0, n_bad = 0, tdiv = 0;
  int tk_off [NCH];
  int tk_ss  [NCH];
  logic watch0 = 1'b0, watch1 = 1'b0;
  int dist0 = 0, dist1 = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: sample just after the edge, then present this cycle's tick
  task automatic cyc();
    @(posedge clk);
    #2;
    us_tick = (tdiv == TP - 1);
    tdiv = (tdiv + 1) % TP;
    for (int c = 0; c < NCH; c++) begin
      if (us_tick && !sw_en[c]) tk_off[c]++;
      if (us_tick && ss_active[c]) tk_ss[c]++;
    end
    if (watch0 && (!sw_en[0] || pg_low[0])) dist0++;
    if (watch1 && (!sw_en[1] || pg_low[1])) dist1++;
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  // leaves the bench in the cycle right after a tick
  task automatic align();
    do cyc(); while (!us_tick);
    cyc();
  endtask

  task automatic wait_on(input logic [NCH-1:0] m);
    for (int k = 0; k < 2000; k++) begin
      if ((sw_en & m) == m) break;
      cyc();
    end
  endtask

  task automatic wait_done(input logic [NCH-1:0] m);
    for (int k = 0; k < 2000; k++) begin
      if ((ss_done & m) == m) break;
      cyc();
    end
  endtask

  task automatic clr_off();
    for (int c = 0; c < NCH; c++) tk_off[c] = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n, cfgs;
    logic seen;
    for (int c = 0; c < NCH; c++) begin tk_off[c] = 0; tk_ss[c] = 0; end

    // R1 reset state
    cycles(3);
    check("R1 sw_en", int'(sw_en), 0);
    check("R1 pg_low", int'(pg_low), 3);
    check("R1 ss flags", int'({ss_active, ss_done}), 0);
    check("R1 cfg_load", int'(cfg_load), 0);

    // R2: enables settled but no bias, nothing may switch
    rst_n = 1'b1;
    en_raw = 2'b11;
    cycles(40);
    check("R2 no switch before init", int'(sw_en), 0);

    // R2 init window length and strobe, R5 soft-start length
    tk_ss[0] = 0; tk_ss[1] = 0;
    bias_ok = 1'b1;
    cfgs = 0; seen = 1'b0; n = 0;
    for (int k = 0; k < 400; k++) begin
      cyc();
      if (cfg_load) begin cfgs++; seen = 1'b1; end
      if (seen && us_tick && sw_en == 0) n++;
      if (sw_en != 0) break;
    end
    check("R2 init ticks", n, INIT);
    check("R2 cfg_load pulses", cfgs, 1);
    check("R5 both start together", int'(sw_en), 3);
    // R10: overvoltage during soft-start must be ignored
    ov_flt[0] = 1'b1;
    cycles(20);
    ov_flt[0] = 1'b0;
    wait_done(2'b11);
    check("R5 R10 ch0 ramp ticks", tk_ss[0], SS);
    check("R5 ch1 ramp ticks", tk_ss[1], SS);
    check("R5 pg released", int'(pg_low), 0);
    check("R5 ramp flag cleared", int'(ss_active), 0);

    // R10 short overvoltage in run ignored; R12 ch1 watched
    watch1 = 1'b1; dist1 = 0;
    align();
    ov_flt[0] = 1'b1;
    n = 0;
    while (n < OVDG - 1) begin cyc(); if (us_tick) n++; end
    ov_flt[0] = 1'b0;
    cycles(20);
    check("R10 short ov ignored", int'(sw_en[0]), 1);

    // R10 deglitch length, R7 hiccup length
    align();
    ov_flt[0] = 1'b1;
    clr_off();
    n = 0;
    for (int k = 0; k < 200; k++) begin
      cyc();
      if (!sw_en[0]) break;
      if (us_tick) n++;
    end
    check("R10 ov deglitch ticks", n, OVDG);
    ov_flt[0] = 1'b0;
    check("R10 pg low after ov", int'(pg_low[0]), 1);
    wait_on(2'b01);
    check("R7 hiccup ticks after ov", tk_off[0], HIC);
    wait_done(2'b01);

    // R11 immediate stop, R8 re-armed hiccup
    oc_flt[0] = 1'b1;
    clr_off();
    cyc();
    check("R11 oc stops next cycle", int'(sw_en[0]), 0);
    cycles((HIC + 4) * TP - 1);
    oc_flt[0] = 1'b0;
    wait_on(2'b01);
    check("R8 rearmed hiccup ticks", tk_off[0], 2 * HIC);
    wait_done(2'b01);
    check("R12 ch1 undisturbed by ch0", dist1, 0);
    watch1 = 1'b0;

    // R6 undervoltage, R7 hiccup on both
    vin_uv = 2'b11;
    clr_off();
    cyc();
    check("R6 uv stops switching", int'(sw_en), 0);
    check("R6 uv pulls pg low", int'(pg_low), 3);
    vin_uv = 2'b00;
    wait_on(2'b11);
    check("R7 ch0 uv hiccup ticks", tk_off[0], HIC);
    check("R7 ch1 uv hiccup ticks", tk_off[1], HIC);
    wait_done(2'b11);

    // R9 overtemperature: no timer
    ot_flt = 1'b1;
    cyc();
    check("R9 ot stops switching", int'(sw_en), 0);
    cycles(30);
    check("R9 held off while hot", int'(sw_en), 0);
    ot_flt = 1'b0;
    cyc();
    check("R9 restart next cycle", int'(sw_en), 3);
    wait_done(2'b11);

    // R4 enable fall on ch1, R12 ch0 watched
    watch0 = 1'b1; dist0 = 0;
    align();
    en_raw[1] = 1'b0;
    n = 0;
    while (n < FALL - 1) begin cyc(); if (us_tick) n++; end
    en_raw[1] = 1'b1;
    cycles(30);
    check("R4 short low ignored", int'(sw_en[1]), 1);
    align();
    en_raw[1] = 1'b0;
    n = 0;
    for (int k = 0; k < 200; k++) begin
      cyc();
      if (!sw_en[1]) break;
      if (us_tick) n++;
    end
    check("R4 fall ticks", n, FALL);
    check("R4 pg low after disable", int'(pg_low[1]), 1);

    // R3 enable rise on ch1
    cycles(20);
    align();
    en_raw[1] = 1'b1;
    n = 0;
    while (n < RISE - 1) begin cyc(); if (us_tick) n++; end
    en_raw[1] = 1'b0;
    cycles(40);
    check("R3 short high ignored", int'(sw_en[1]), 0);
    align();
    en_raw[1] = 1'b1;
    n = 0;
    for (int k = 0; k < 400; k++) begin
      cyc();
      if (sw_en[1]) break;
      if (us_tick) n++;
    end
    check("R3 rise ticks", n, RISE);
    wait_done(2'b11);
    check("R12 ch0 undisturbed by ch1", dist0, 0);
    watch0 = 1'b0;

    // R13 bias loss, R2 undervoltage blocks start after init
    bias_ok = 1'b0;
    cyc();
    cyc();
    check("R13 off after bias loss", int'(sw_en), 0);
    check("R13 pg low after bias loss", int'(pg_low), 3);
    vin_uv = 2'b11;
    bias_ok = 1'b1;
    cfgs = 0;
    for (int k = 0; k < (INIT + 4) * TP; k++) begin
      cyc();
      if (cfg_load) cfgs++;
    end
    check("R13 new cfg strobe", cfgs, 1);
    check("R2 uv blocks start", int'(sw_en), 0);
    vin_uv = 2'b00;
    cyc();
    check("R2 start once uv clears", int'(sw_en), 3);

    finish_run();
  end

endmodule